// File: doc/BRIEF.md
# I2C Serial EEPROM Slave (Read Model)

This block models a small serial EEPROM of the kind that holds memory-module presence data. A bit-banging master writes clock and data levels into the block one update at a time. The block watches those levels for start conditions. It then shifts in a command byte and a one-byte word address, acknowledging each byte. The byte at that address is returned serially on the data line during the address phase of the next read transfer.

Each update is marked by a one-cycle strobe. The block compares the new clock and data levels with the ones it stored at the previous update. From that comparison it classifies the update as a start, a stop, a clock rising edge with steady data, or a rising edge where data also moved. The data line is open-drain. `sda_o` is the wired-AND line level that the master reads back, and `sda_pull_o` flags that the slave itself is pulling it low. The contents come from a parameterised image computed at elaboration. The block never writes to it.

The read-out is pipelined in an unusual way. The byte shifted out during an address phase is the one latched at the end of the previous transfer. That previous transfer can be a write-mode transfer that only sets the address. At the end of each address phase, the byte at the address just received is latched for the next read.

Top module: `i2c_eep_slave`

## Requirements
- R1: After reset, `sda_o` is 1 and `sda_pull_o` is 0. The stored clock and data levels are both 1, and the bit counter, acknowledge flag, command, address and data registers are zero.
- R2: A start (data falls from 1 to 0 while the clock is 1 at both updates) restarts the transfer from its first command bit, even in the middle of a transfer. The eighth counted bit after a start makes an acknowledge pending.
- R3: While no transfer is active and no acknowledge is pending, clock edges have no effect. `sda_pull_o` stays 0 and `sda_o` follows `sda_i`.
- R4: A bit is captured only at a clock rising edge where the data level equals the level stored at the previous update. A rising edge that also changes data is not counted.
- R5: A pending acknowledge is served at the next clock rising edge by pulling the line low (`sda_pull_o`=1, `sda_o`=0). The pull is released at the next update that has the clock low.
- R6: A stop (data rises from 0 to 1 while the clock is 1 at both updates) starts no transfer. Clock edges after a stop at idle produce no acknowledge.
- R7: Command and address bits are received MSB first. Command bit 0 selects read (1) or write (0). In read mode, each address-phase rising edge drives the line with the MSB of the data register, ANDed with the master level, and the register then shifts left.
- R8: After the eighth address bit, the data register loads the byte at the received address, an acknowledge becomes pending, and the block returns to idle.
- R9: The default image holds 0x80, 0x08, 0x04, 0x0D at addresses 0 to 3, 0x12 at 0x3E, 0xF4 at 0x7F, and 0x00 at 0xFF.
- R10: Outputs change only in the cycle after an update strobe (`wr_i`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Update strobe: new bus levels present on `scl_i`/`sda_i` |
| scl_i | input | 1 | Clock level written by the master |
| sda_i | input | 1 | Data level driven by the master (1 = released) |
| sda_o | output | 1 | Wired-AND data line level seen by the master |
| sda_pull_o | output | 1 | Slave is pulling the data line low |

## Verification
The hardest state to reach from the ports is a data read-out. It needs two complete transfers in sequence. A write-mode transfer sets the address and latches a byte. A second, read-mode transfer then clocks that byte out while its own address bits are still arriving. The bench therefore chains these transfers for several addresses. It also runs one more read with no fresh address set, so the value latched from the all-ones address of the previous read is observed. Ignored rising edges are reached by moving data and clock in the same update partway through a command byte. The check is that the acknowledge arrives one edge later than it would otherwise.

// File: rtl/i2c_eep_pkg.sv
`timescale 1ns/1ps
package i2c_eep_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TICK_W = 5;
  localparam logic [TICK_W-1:0] TICK_CMD_DONE = TICK_W'(9);
  localparam logic [TICK_W-1:0] TICK_ADR_DONE = TICK_W'(17);

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic steady;
  } bus_ev_t;

  // presence-data style default image; unlisted bytes are zero
  function automatic logic [BYTE_W-1:0] spd_byte(int unsigned idx);
    case (idx)
      0:   return 8'h80;
      1:   return 8'h08;
      2:   return 8'h04;
      3:   return 8'h0D;
      4:   return 8'h0A;
      5:   return 8'h01;
      6:   return 8'h40;
      8:   return 8'h01;
      9:   return 8'h75;
      10:  return 8'h54;
      12:  return 8'h82;
      13:  return 8'h08;
      62:  return 8'h12;
      63:  return 8'hD0;
      126: return 8'h64;
      127: return 8'hF4;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_eep_cond.sv
`timescale 1ns/1ps
module i2c_eep_cond
  import i2c_eep_pkg::*;
(
  input  logic    scl_q_i,
  input  logic    sda_q_i,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_hold;
  assign scl_hold     = scl_q_i & scl_i;
  assign ev_o.start   = scl_hold & sda_q_i & ~sda_i;
  assign ev_o.stop    = scl_hold & ~sda_q_i & sda_i;
  assign ev_o.rise    = ~scl_q_i & scl_i;
  assign ev_o.steady  = (sda_q_i == sda_i);
endmodule

// File: rtl/i2c_eep_rom.sv
`timescale 1ns/1ps
module i2c_eep_rom
  import i2c_eep_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] image [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_img
    assign image[g] = spd_byte(g);
  end

  assign data_o = image[idx_i];
endmodule

// File: rtl/i2c_eep_slave.sv
`timescale 1ns/1ps
module i2c_eep_slave
  import i2c_eep_pkg::*;
#(
  parameter int unsigned MEM_DEPTH = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_pull_o
);
  localparam int unsigned IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  logic              scl_q, sda_q, pull_q;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              ack_q, ack_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d, addr_q, addr_d, data_q, data_d;
  logic [BYTE_W-1:0] addr_nx, rom_byte;
  logic              drive, slv_bit, active;
  bus_ev_t           ev;

  i2c_eep_cond u_cond (
    .scl_q_i(scl_q),
    .sda_q_i(sda_q),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .ev_o   (ev)
  );

  assign addr_nx = {addr_q[BYTE_W-2:0], sda_i};

  i2c_eep_rom #(.DEPTH(MEM_DEPTH)) u_rom (
    .idx_i (addr_nx[IDX_W-1:0]),
    .data_o(rom_byte)
  );

  assign active = (tick_q != '0) | ack_q;

  always_comb begin
    tick_d  = tick_q;
    ack_d   = ack_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    data_d  = data_q;
    drive   = 1'b0;
    slv_bit = 1'b1;
    if (ev.start) begin
      tick_d = TICK_W'(1);
      cmd_d  = '0;
    end else if (!ev.stop && active && ev.rise) begin
      if (ack_q) begin
        drive   = 1'b1;
        slv_bit = 1'b0;
        ack_d   = 1'b0;
      end else if (ev.steady) begin
        if (tick_q < TICK_CMD_DONE) begin
          cmd_d  = {cmd_q[BYTE_W-2:0], sda_i};
          tick_d = tick_q + TICK_W'(1);
          if (tick_q == TICK_CMD_DONE - TICK_W'(1)) ack_d = 1'b1;
        end else begin
          if (cmd_q[0]) begin
            drive   = 1'b1;
            slv_bit = data_q[BYTE_W-1];
          end
          addr_d = addr_nx;
          data_d = {data_q[BYTE_W-2:0], 1'b0};
          tick_d = tick_q + TICK_W'(1);
          if (tick_q == TICK_ADR_DONE - TICK_W'(1)) begin
            data_d = rom_byte;
            ack_d  = 1'b1;
            tick_d = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      pull_q <= 1'b0;
      tick_q <= '0;
      ack_q  <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (wr_i) begin
      scl_q  <= scl_i;
      sda_q  <= sda_i & slv_bit;  // wired-AND with slave drive
      pull_q <= drive & ~slv_bit;
      tick_q <= tick_d;
      ack_q  <= ack_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign sda_o      = sda_q;
  assign sda_pull_o = pull_q;
endmodule

// File: rtl/i2c_eep_sva.sv
`timescale 1ns/1ps
module i2c_eep_sva
  import i2c_eep_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_o,
  input logic              sda_pull_o,
  input logic              scl_q,
  input logic [TICK_W-1:0] tick_q,
  input logic              ack_q
);
  logic is_start;
  assign is_start = scl_q & scl_i & sda_o & ~sda_i;

  assert_pull_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> !sda_o);

  assert_ack_served_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ack_q && !scl_q && scl_i) |=> (sda_pull_o && !ack_q));

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !scl_i) |=> !sda_pull_o);

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tick_q == '0 && !ack_q && !is_start) |=> (!sda_pull_o && tick_q == '0));

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_start) |=> (tick_q == TICK_W'(1)));

  assert_tick_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q < TICK_ADR_DONE);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(sda_o) && $stable(sda_pull_o)));
endmodule

bind i2c_eep_slave i2c_eep_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .scl_i     (scl_i),
  .sda_i     (sda_i),
  .sda_o     (sda_o),
  .sda_pull_o(sda_pull_o),
  .scl_q     (scl_q),
  .tick_q    (tick_q),
  .ack_q     (ack_q)
);

// File: tb/tb_i2c_eep_slave.sv
`timescale 1ns/1ps
module tb_i2c_eep_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_o, pull;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_eep_slave dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_i      (wr),
    .scl_i     (scl_m),
    .sda_i     (sda_m),
    .sda_o     (sda_o),
    .sda_pull_o(pull)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one master update; outputs are valid on return
  task automatic put(logic c, logic d);
    @(negedge clk);
    scl_m = c; sda_m = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic go_start();
    put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b0); put(1'b0, 1'b0);
  endtask

  task automatic go_stop();
    put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1);
  endtask

  task automatic send_byte(logic [7:0] b, string req);
    for (int i = 7; i >= 0; i--) begin
      put(1'b0, b[i]); put(1'b1, b[i]);
      check(req, "no pull while byte shifts in", pull, 1'b0);
    end
  endtask

  task automatic ack_clk(string req);
    put(1'b0, 1'b1); put(1'b1, 1'b1);
    check(req, "ack pull", pull, 1'b1);
    check(req, "ack line low", sda_o, 1'b0);
    put(1'b0, 1'b1);
    check("R5", "ack released on clock low", pull, 1'b0);
  endtask

  task automatic set_addr(logic [7:0] a);
    go_start();
    send_byte(8'hA0, "R2");
    ack_clk("R5");
    send_byte(a, "R7");
    ack_clk("R8");
    go_stop();
  endtask

  task automatic read_byte(output logic [7:0] v);
    go_start();
    send_byte(8'hA1, "R7");
    ack_clk("R5");
    for (int i = 7; i >= 0; i--) begin
      put(1'b0, 1'b1); put(1'b1, 1'b1);
      v[i] = sda_o;
    end
    ack_clk("R8");
    go_stop();
  endtask

  task automatic t_reset();
    check("R1", "line after reset", sda_o, 1'b1);
    check("R1", "pull after reset", pull, 1'b0);
  endtask

  task automatic t_idle();
    logic [4:0] pat = 5'b10011;
    for (int i = 4; i >= 0; i--) begin
      put(1'b0, pat[i]); put(1'b1, pat[i]);
      check("R3", "idle no pull", pull, 1'b0);
      check("R3", "idle line follows master", sda_o, pat[i]);
    end
  endtask

  task automatic t_image();
    logic [7:0] adr [6] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h3E, 8'h7F};
    logic [7:0] exp [6] = '{8'h80, 8'h08, 8'h04, 8'h0D, 8'h12, 8'hF4};
    logic [7:0] v;
    for (int k = 0; k < 6; k++) begin
      set_addr(adr[k]);
      read_byte(v);
      check("R9", $sformatf("byte at %0h", adr[k]), v, exp[k]);
    end
    // previous read shifted in address 0xFF
    read_byte(v);
    check("R8", "byte latched from all-ones address", v, 8'h00);
  endtask

  task automatic t_stop();
    go_stop();
    for (int i = 0; i < 9; i++) begin
      put(1'b0, i[0]); put(1'b1, i[0]);
      check("R6", "no transfer after stop", pull, 1'b0);
    end
  endtask

  task automatic t_restart();
    go_start();
    put(1'b0, 1'b1); put(1'b1, 1'b1);
    put(1'b0, 1'b0); put(1'b1, 1'b0);
    put(1'b0, 1'b1); put(1'b1, 1'b1);
    go_start();
    send_byte(8'hA0, "R2");
    // clock raised without strobe: nothing may happen
    @(negedge clk); scl_m = 1'b0; sda_m = 1'b1;
    @(negedge clk); scl_m = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "no ack without strobe", pull, 1'b0);
    scl_m = 1'b0;
    ack_clk("R2");
  endtask

  task automatic t_glitch();
    logic [6:0] head = 7'b1010000;
    go_start();
    for (int i = 6; i >= 0; i--) begin
      put(1'b0, head[i]); put(1'b1, head[i]);
    end
    put(1'b0, 1'b0); put(1'b1, 1'b1);
    check("R4", "edge with data change not counted", pull, 1'b0);
    put(1'b0, 1'b0); put(1'b1, 1'b0);
    check("R4", "eighth counted bit gives no pull", pull, 1'b0);
    ack_clk("R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_image();
    t_stop();
    t_restart();
    t_glitch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule